// File: doc/BRIEF.md
# Two-Channel 8-Bit PWM Generator

This block drives two pulse-width modulated outputs from one shared 16-bit free-running count. The count advances on a selectable tick: either one of several binary taps of an internal prescaler running on the system clock, or the rising edges of an external clock pin after synchronisation. Each channel looks at the count through its own 8-bit window. The low byte gives a fast timebase and the high byte gives a slow one, so the two outputs can run at periods 256 times apart from the same counter.

Each channel has an output latch. The latch goes high when the channel's window rolls over to zero and goes low when the window steps onto the channel's active duty value, so a duty value d gives d counts high out of 256. Duty values are written into a per-channel buffer. A buffered value becomes active only when that channel's window wraps, so a period is never cut short or stretched by a write. A per-channel force input holds the output high, which is the only way to reach 100% duty.

Top module: `dual_pwm_gen`

## Requirements
- R1: While reset is asserted, `cnt_o` is 0 and both bits of `pwm_o` are 0.
- R2: With `clk_sel_i` = k, where k is less than NUM_TAPS (4), `cnt_o` advances by exactly one every 2^k clock cycles and holds in between.
- R3: With `clk_sel_i` at NUM_TAPS or above, `cnt_o` advances once per rising edge of `ext_clk_i` and holds while that pin stays low.
- R4: A channel with its `slow_i` bit at 0 uses window `cnt_o[7:0]`. A channel with its `slow_i` bit at 1 uses window `cnt_o[15:8]`. Bit n of each per-channel vector belongs to channel n: channel A is bit 0 and channel B is bit 1.
- R5: Once a channel's window has wrapped at least once, with active duty d not 0, its output is high exactly while the window value is below d. The output changes in the same cycle as the count.
- R6: An active duty of 0 keeps the output low, including on the count where the window wraps: reset wins over set.
- R7: While a channel's `force_hi_i` bit is 1, its output is high from the next cycle on, whatever the count. After the force is released, normal operation resumes.
- R8: A write to `duty_wr_i[n]` with `duty_data_i[8n+7:8n]` goes into a buffer. It becomes the active duty only when channel n's window wraps from 0xFF to 0x00, so a write in the middle of a period leaves that period unchanged.
- R9: The two channels are independent in duty, mode and force.
- R10: After reset, a channel's output stays low until its window wraps for the first time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_clk_i | input | 1 | External count clock, synchronised inside |
| clk_sel_i | input | 3 | Tick source: 0..3 selects prescaler tap (divide by 2^k); 4 or more selects the external clock |
| slow_i | input | 2 | Per-channel window select: 0 = low byte, 1 = high byte |
| force_hi_i | input | 2 | Per-channel force-high (100% duty) |
| duty_wr_i | input | 2 | Per-channel duty buffer write strobe |
| duty_data_i | input | 16 | Duty values, channel n in bits [8n+7:8n] |
| cnt_o | output | 16 | Shared free-running count |
| pwm_o | output | 2 | PWM outputs, channel n on bit n |

## Verification
Channel A is swept in fast mode over every one of the 256 duty values, and every count of a full period is compared with the "window below duty" rule. This separates an off-by-one at the match from a wrong set point, and covers the duty 0 and 0xFF edges. For the whole sweep channel B runs in slow mode with a fixed duty. It must stay low for the 65536 counts before its first high-byte wrap and then show exactly 1024 high counts, which tells the two windows apart and shows the channels do not disturb each other. Separate patterns write a duty mid-period to show the old value still rules that period, hold the force across match points, and measure the tick spacing for several prescaler taps and for pulses on the external pin.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

    localparam int unsigned SLICE_W = 8;
    localparam int unsigned CNT_W   = 2 * SLICE_W;

    typedef logic [SLICE_W-1:0] slice_t;
    typedef logic [CNT_W-1:0]   count_t;

    typedef struct packed {
        slice_t buf_v;
        slice_t act;
        logic   out;
    } chan_state_t;

endpackage

// File: rtl/dpwm_timebase.sv
module dpwm_timebase
    import dpwm_pkg::*;
#(
    parameter int unsigned NUM_TAPS = 4,
    parameter int unsigned SEL_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_clk_i,
    input  logic [SEL_W-1:0] clk_sel_i,
    output logic             tick_o,
    output count_t           cnt_o,
    output count_t           cnt_next_o
);

    localparam int unsigned PRE_W = (NUM_TAPS > 1) ? NUM_TAPS - 1 : 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [1:0]       sync;
        logic             ext_prev;
        count_t           cnt;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic [NUM_TAPS-1:0] tap_tick;
    logic ext_edge;

    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
        if (k == 0) begin : g_every
            assign tap_tick[k] = 1'b1;
        end else begin : g_div
            assign tap_tick[k] = &st_q.pre[k-1:0];
        end
    end

    always_comb begin
        ext_edge = st_q.sync[1] & ~st_q.ext_prev;
        tick_o   = ext_edge;
        for (int k = 0; k < NUM_TAPS; k++) begin
            if (clk_sel_i == SEL_W'(k)) tick_o = tap_tick[k];
        end
        st_d          = st_q;
        st_d.pre      = st_q.pre + 1'b1;
        st_d.sync     = {st_q.sync[0], ext_clk_i};
        st_d.ext_prev = st_q.sync[1];
        if (tick_o) st_d.cnt = st_q.cnt + 1'b1;
        cnt_o      = st_q.cnt;
        cnt_next_o = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_TICK_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (cnt_o == $past(cnt_next_o))); // R2
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_o |=> $stable(cnt_o)); // R2
    AST_EXT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((clk_sel_i >= SEL_W'(NUM_TAPS)) && !st_q.sync[1]) |-> !tick_o); // R3

endmodule

// File: rtl/dpwm_channel.sv
module dpwm_channel
    import dpwm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick_i,
    input  count_t cnt_i,
    input  count_t cnt_next_i,
    input  logic   slow_i,
    input  logic   force_i,
    input  logic   wr_en_i,
    input  slice_t wr_data_i,
    output logic   pwm_o
);

    chan_state_t st_d, st_q;
    slice_t old_s, new_s, duty_eff;
    logic step, wrap;

    always_comb begin
        old_s    = slow_i ? cnt_i[CNT_W-1:SLICE_W]      : cnt_i[SLICE_W-1:0];
        new_s    = slow_i ? cnt_next_i[CNT_W-1:SLICE_W] : cnt_next_i[SLICE_W-1:0];
        step     = tick_i && (new_s != old_s);
        wrap     = step && (new_s == '0);
        duty_eff = wrap ? st_q.buf_v : st_q.act;

        st_d = st_q;
        if (wr_en_i) st_d.buf_v = wr_data_i;
        if (wrap)    st_d.act   = st_q.buf_v;
        if (force_i)                           st_d.out = 1'b1;
        else if (step && (new_s == duty_eff))  st_d.out = 1'b0;
        else if (wrap)                         st_d.out = 1'b1;

        pwm_o = st_q.out;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        force_i |=> pwm_o); // R7
    AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_i && wrap && (st_q.buf_v == '0)) |=> !pwm_o); // R6
    AST_SET_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_i && wrap && (st_q.buf_v != '0)) |=> pwm_o); // R5
    AST_RESET_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_i && step && !wrap && (new_s == st_q.act)) |=> !pwm_o); // R5
    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(st_q.act)); // R8

endmodule

// File: rtl/dual_pwm_gen.sv
module dual_pwm_gen
    import dpwm_pkg::*;
#(
    parameter  int unsigned NUM_TAPS = 4,
    parameter  int unsigned NCH      = 2,
    localparam int unsigned SEL_W    = $clog2(NUM_TAPS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ext_clk_i,
    input  logic [SEL_W-1:0]       clk_sel_i,
    input  logic [NCH-1:0]         slow_i,
    input  logic [NCH-1:0]         force_hi_i,
    input  logic [NCH-1:0]         duty_wr_i,
    input  logic [NCH*SLICE_W-1:0] duty_data_i,
    output logic [CNT_W-1:0]       cnt_o,
    output logic [NCH-1:0]         pwm_o
);

    logic   tick;
    count_t cnt_q, cnt_nx;

    dpwm_timebase #(
        .NUM_TAPS (NUM_TAPS),
        .SEL_W    (SEL_W)
    ) u_timebase (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_clk_i  (ext_clk_i),
        .clk_sel_i  (clk_sel_i),
        .tick_o     (tick),
        .cnt_o      (cnt_q),
        .cnt_next_o (cnt_nx)
    );

    assign cnt_o = cnt_q;

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        dpwm_channel u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick_i     (tick),
            .cnt_i      (cnt_q),
            .cnt_next_i (cnt_nx),
            .slow_i     (slow_i[n]),
            .force_i    (force_hi_i[n]),
            .wr_en_i    (duty_wr_i[n]),
            .wr_data_i  (duty_data_i[n*SLICE_W +: SLICE_W]),
            .pwm_o      (pwm_o[n])
        );
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> ((cnt_o == '0) && (pwm_o == '0))); // R1

endmodule

// File: tb/dual_pwm_gen_test.sv
module dual_pwm_gen_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_clk = 1'b0;
    logic [2:0]  clk_sel = 3'd0;
    logic [1:0]  slow = 2'b10;
    logic [1:0]  force_hi = 2'b00;
    logic [1:0]  duty_wr = 2'b00;
    logic [15:0] duty_data = 16'h0400;
    logic [15:0] cnt_o;
    logic [1:0]  pwm_o;

    int n_chk = 0;
    int n_fail = 0;
    logic        b_mon = 1'b0;
    logic        b_wrapped = 1'b0;
    logic [15:0] prev_cnt = '0;

    dual_pwm_gen uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_clk_i   (ext_clk),
        .clk_sel_i   (clk_sel),
        .slow_i      (slow),
        .force_hi_i  (force_hi),
        .duty_wr_i   (duty_wr),
        .duty_data_i (duty_data),
        .cnt_o       (cnt_o),
        .pwm_o       (pwm_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string what, input int ctx, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s (ctx %0d): actual %0d expected %0d", what, ctx, act, exp);
        end
    endtask

    // one clock; channel B is watched in slow mode while b_mon is set
    task automatic step();
        @(negedge clk);
        if (prev_cnt == 16'hFFFF && cnt_o == 16'h0000) b_wrapped = 1'b1;
        prev_cnt = cnt_o;
        if (b_mon)
            chk("R4 R9 R10 slow channel B", int'(cnt_o),
                int'(pwm_o[1]), int'(b_wrapped && (cnt_o[15:8] < 8'd4)));
    endtask

    task automatic wait_low(input logic [7:0] v);
        while (cnt_o[7:0] != v) step();
    endtask

    task automatic write_a(input logic [7:0] d);
        duty_wr[0] = 1'b1;
        duty_data[7:0] = d;
        step();
        duty_wr[0] = 1'b0;
    endtask

    // full fast period of channel A checked against "window below duty"
    task automatic check_period_a(input int d, input string what);
        wait_low(8'hFF);
        for (int i = 0; i < 256; i++) begin
            step();
            chk(what, d * 256 + int'(cnt_o[7:0]), int'(pwm_o[0]),
                int'(int'(cnt_o[7:0]) < d));
        end
    endtask

    task automatic measure_tap(input int sel, input int per);
        int n;
        logic [15:0] c;
        clk_sel = 3'(sel);
        repeat (20) step();
        c = cnt_o;
        while (cnt_o == c) step();
        for (int i = 0; i < 4; i++) begin
            n = 0;
            c = cnt_o;
            while (cnt_o == c) begin
                step();
                n++;
            end
            chk("R2 tick spacing", sel, n, per);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] c0;
        repeat (3) @(negedge clk);
        chk("R1 reset count", 0, int'(cnt_o), 0);
        chk("R1 reset outputs", 0, int'(pwm_o), 0);
        rst_n = 1'b1;

        // channel B: slow window, duty 4, buffered before its first wrap
        duty_wr[1] = 1'b1;
        step();
        duty_wr[1] = 1'b0;
        b_mon = 1'b1;

        // R5 R6 R9: exhaustive duty sweep on fast channel A
        for (int d = 0; d < 256; d++) begin
            write_a(8'(d));
            if (d == 0) check_period_a(d, "R6 duty zero stays low");
            else        check_period_a(d, "R5 R4 fast channel A");
        end
        chk("R10 slow channel B wrapped during sweep", 0, int'(b_wrapped), 1);
        b_mon = 1'b0;

        // R8: mid-period write keeps the running period
        write_a(8'h80);
        wait_low(8'hFF);
        wait_low(8'h10);
        write_a(8'h20);
        wait_low(8'h40);
        chk("R8 old duty still active", 8'h40, int'(pwm_o[0]), 1);
        wait_low(8'h90);
        chk("R8 old duty match point", 8'h90, int'(pwm_o[0]), 0);
        wait_low(8'h10);
        chk("R8 new duty after wrap high", 8'h10, int'(pwm_o[0]), 1);
        wait_low(8'h40);
        chk("R8 new duty after wrap low", 8'h40, int'(pwm_o[0]), 0);

        // R7: force high across match points, then resume
        force_hi[0] = 1'b1;
        step();
        for (int i = 0; i < 300; i++) begin
            chk("R7 forced high", i, int'(pwm_o[0]), 1);
            step();
        end
        force_hi[0] = 1'b0;
        check_period_a(8'h20, "R7 resume after force");

        // R2: prescaler taps
        measure_tap(1, 2);
        measure_tap(2, 4);
        measure_tap(3, 8);

        // R3: external clock
        clk_sel = 3'd4;
        ext_clk = 1'b0;
        repeat (10) step();
        c0 = cnt_o;
        repeat (40) step();
        chk("R3 holds without edges", 0, int'(cnt_o), int'(c0));
        for (int p = 0; p < 10; p++) begin
            ext_clk = 1'b1;
            repeat (5) step();
            ext_clk = 1'b0;
            repeat (5) step();
        end
        repeat (5) step();
        chk("R3 one count per edge", 10, int'(cnt_o - c0), 10);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule